// File: doc/BRIEF.md
# Stereo Soft Mute with Bit-Clock Loss Detection

This block is a gain stage on a stream of signed 24-bit stereo samples. An active-low mute pin requests silence, and a watchdog on the serial bit clock raises its own mute request when that clock stops toggling. Either request makes the block fade both channels toward zero, stepping the gain down by a fixed amount on every sample strobe, so that silence arrives after a fixed number of samples (800 by default).

Releasing the request is asymmetric: the gain snaps back to unity on the next system clock, with no upward ramp. A release during a fade jumps straight to unity; a new request later starts a fresh fade from whatever gain is held at that moment. Each sample is multiplied by the current gain and rounded back to 24 bits, so unity gain passes data unchanged and zero gain yields exact zero.

Top module: `stereo_fade_mute`

## Requirements
- R1: `mute_n_i` is active low: 0 requests a fade, 1 means normal operation.
- R2: Both channels always use the same gain; equal left and right inputs give equal outputs.
- R3: While a mute is requested, each strobe on `smp_valid_i` lowers `gain_o` by STEP = ceil(2^20/800) = 1311, clamped at 0; with no strobe the gain holds. From unity, 799 strobes leave 1087 and the 800th leaves 0.
- R4: Whenever no mute is requested, `gain_o` equals unity (2^20 = 1048576) on the next clock, whether or not a strobe is present and even in the middle of a fade.
- R5: When the bit clock shows no edge for TIMEOUT (64) system clocks, `bclk_lost_o` goes to 1 and acts as a mute request; a bit-clock edge clears it again.
- R6: `out_valid_o` rises one clock after a strobe; each output equals (sample * gain + 2^19) >> 20 with arithmetic shift (round half up), using the gain held in the strobe cycle.
- R7: At unity gain the output equals the input sample exactly; at zero gain the output is exactly 0.
- R8: During reset `gain_o`, `out_left_o`, `out_right_o`, `out_valid_o` and `bclk_lost_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_n_i | input | 1 | Mute request, 0 = mute |
| bclk_i | input | 1 | Serial bit clock, watched for activity |
| smp_valid_i | input | 1 | Sample strobe |
| smp_left_i | input | 24 | Left sample, two's complement |
| smp_right_i | input | 24 | Right sample, two's complement |
| out_valid_o | output | 1 | Output strobe, one clock after input strobe |
| out_left_o | output | 24 | Scaled left sample |
| out_right_o | output | 24 | Scaled right sample |
| gain_o | output | 21 | Current gain, unity = 2^20 |
| bclk_lost_o | output | 1 | Bit clock judged stopped |

## Verification
The sample strobe and a change of the mute pin can land in the same clock: the strobe must then be scaled by the gain held before the change, while the gain register takes the new direction (a step down on assertion, unity on release). The stimulus table drives mute edges together with strobes, and a bench model that tracks the gain on its own predicts both the scaled output of that strobe and the gain seen afterward.

// File: rtl/stereo_fade_pkg.sv
package stereo_fade_pkg;

  typedef enum logic [1:0] {
    FADE_UNITY  = 2'd0,
    FADE_RAMP   = 2'd1,
    FADE_SILENT = 2'd2
  } fade_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bclk_watch.sv
module bclk_watch #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  output logic lost_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] quiet_q;
  logic             edge_seen;

  assign edge_seen = sync_q[1] ^ sync_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      quiet_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], bclk_i};
      if (edge_seen)
        quiet_q <= '0;
      else if (quiet_q != LIMIT)
        quiet_q <= quiet_q + 1'b1;
    end
  end

  assign lost_o = (quiet_q == LIMIT);

  assert_quiet_flags_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q == LIMIT - 1'b1 && !edge_seen) |=> lost_o);
  assert_edge_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !lost_o);
endmodule

// File: rtl/fade_gain_ctrl.sv
module fade_gain_ctrl
  import stereo_fade_pkg::*;
#(
  parameter int GAIN_FRAC = 20,
  parameter int RAMP_LEN  = 800,
  localparam int GAIN_W   = GAIN_FRAC + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_req_i,
  input  logic              strobe_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int UNITY = 1 << GAIN_FRAC;
  localparam int STEP  = ceil_div(UNITY, RAMP_LEN);
  localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(UNITY);
  localparam logic [GAIN_W-1:0] STEP_G  = GAIN_W'(STEP);

  fade_state_e       state_q;
  logic [GAIN_W-1:0] gain_q;
  logic              ramp_step;
  logic              ramp_last;

  assign ramp_step = mute_req_i && strobe_i;
  assign ramp_last = ramp_step && (gain_q <= STEP_G);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FADE_SILENT;
      gain_q  <= '0;
    end else if (!mute_req_i) begin
      state_q <= FADE_UNITY;
      gain_q  <= UNITY_G;
    end else if (ramp_last) begin
      state_q <= FADE_SILENT;
      gain_q  <= '0;
    end else if (ramp_step) begin
      state_q <= FADE_RAMP;
      gain_q  <= gain_q - STEP_G;
    end
  end

  assign gain_o = gain_q;

  assert_release_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_req_i |=> (gain_o == UNITY_G));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req_i && strobe_i && gain_o > STEP_G) |=> (gain_o == $past(gain_o) - STEP_G));
  assert_clamp_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req_i && strobe_i && gain_o <= STEP_G) |=> (gain_o == '0));
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req_i && !strobe_i) |=> $stable(gain_o));
  assert_silent_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FADE_SILENT) |-> (gain_o == '0));
  assert_gain_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_o <= UNITY_G);
endmodule

// File: rtl/sample_scale.sv
module sample_scale #(
  parameter int DATA_W    = 24,
  parameter int GAIN_FRAC = 20,
  localparam int GAIN_W   = GAIN_FRAC + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_i,
  input  logic [GAIN_W-1:0]        gain_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] sample_o
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(1 << GAIN_FRAC);

  function automatic logic signed [DATA_W-1:0] scale_round(
    input logic signed [DATA_W-1:0] s,
    input logic [GAIN_W-1:0]        g
  );
    logic signed [PROD_W-1:0] se, ge, p, sh;
    se = PROD_W'(s);
    ge = PROD_W'($signed({1'b0, g}));
    p  = se * ge + (PROD_W'(1) <<< (GAIN_FRAC - 1));
    sh = p >>> GAIN_FRAC;
    return DATA_W'(sh);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      sample_o <= '0;
    else if (valid_i)
      sample_o <= scale_round(sample_i, gain_i);
  end

  assert_zero_gain_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && gain_i == '0) |=> (sample_o == '0));
  assert_unity_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && gain_i == UNITY_G) |=> (sample_o == $past(sample_i)));
endmodule

// File: rtl/stereo_fade_mute.sv
module stereo_fade_mute #(
  parameter int DATA_W      = 24,
  parameter int GAIN_FRAC   = 20,
  parameter int RAMP_LEN    = 800,
  parameter int TIMEOUT_CYC = 64,
  localparam int GAIN_W     = GAIN_FRAC + 1,
  localparam int NUM_CH     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_n_i,
  input  logic              bclk_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              bclk_lost_o
);
  logic                     clk_lost;
  logic                     mute_req;
  logic [GAIN_W-1:0]        gain;
  logic                     valid_q;
  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];

  bclk_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk_i (bclk_i),
    .lost_o (clk_lost)
  );

  assign mute_req = !mute_n_i || clk_lost;

  fade_gain_ctrl #(.GAIN_FRAC(GAIN_FRAC), .RAMP_LEN(RAMP_LEN)) u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_req_i (mute_req),
    .strobe_i   (smp_valid_i),
    .gain_o     (gain)
  );

  assign ch_in[0] = $signed(smp_left_i);
  assign ch_in[1] = $signed(smp_right_i);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    sample_scale #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (smp_valid_i),
      .gain_i   (gain),
      .sample_i (ch_in[ch]),
      .sample_o (ch_out[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= smp_valid_i;
  end

  assign out_valid_o = valid_q;
  assign out_left_o  = ch_out[0];
  assign out_right_o = ch_out[1];
  assign gain_o      = gain;
  assign bclk_lost_o = clk_lost;

  assert_channels_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && smp_left_i == smp_right_i) |=> (out_left_o == out_right_o));
  assert_pin_mute_fades_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_n_i && smp_valid_i && gain_o != '0) |=> (gain_o < $past(gain_o)));
  assert_out_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> out_valid_o);
endmodule

// File: tb/stereo_fade_mute_tb.sv
`timescale 1ns/100ps
module stereo_fade_mute_tb_top;
  localparam longint UNITY = 1048576;
  localparam longint STEP  = (1048576 + 799) / 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mute_n = 1'b1;
  logic        bclk = 1'b0;
  logic        bclk_run = 1'b1;
  logic        valid = 1'b0;
  logic [23:0] left = '0, right = '0;
  logic        out_valid;
  logic [23:0] out_left, out_right;
  logic [20:0] gain;
  logic        lost;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  longint gain_m;

  stereo_fade_mute dut_i (
    .clk(clk), .rst_n(rst_n), .mute_n_i(mute_n), .bclk_i(bclk),
    .smp_valid_i(valid), .smp_left_i(left), .smp_right_i(right),
    .out_valid_o(out_valid), .out_left_o(out_left), .out_right_o(out_right),
    .gain_o(gain), .bclk_lost_o(lost)
  );

  always #2.5 clk = ~clk;
  always begin #10; if (bclk_run) bclk = ~bclk; end

  // {mute_n, left, right}
  localparam logic [48:0] VEC [10] = '{
    {1'b1, 24'h7FFFFF, 24'h800000},
    {1'b1, 24'h123456, 24'hFEDCBA},
    {1'b0, 24'h400000, 24'hC00000},
    {1'b0, 24'h400000, 24'hC00000},
    {1'b0, 24'h7FFFFF, 24'h800000},
    {1'b0, 24'h000001, 24'hFFFFFF},
    {1'b1, 24'h2AAAAA, 24'hD55556},
    {1'b1, 24'h0ABCDE, 24'hF54322},
    {1'b0, 24'h100000, 24'hF00000},
    {1'b1, 24'h7FFFFF, 24'h800001}
  };

  function automatic longint model_scale(longint s, longint g);
    longint p = s * g + 524288;
    if (p >= 0) return p / 1048576;
    return -((-p + 1048575) / 1048576);
  endfunction

  function automatic longint sx(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(logic [23:0] l, logic [23:0] r);
    @(negedge clk);
    valid = 1'b1; left = l; right = r;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    idle(10);
    check(gain == 0, "R8 gain", gain, 0);
    check(out_left == 0 && out_right == 0, "R8 out", sx(out_left), 0);
    check(out_valid == 0, "R8 valid", out_valid, 0);
    check(lost == 0, "R8 lost", lost, 0);
    rst_n = 1'b1;
    idle(1);
    check(gain == UNITY, "R4 unity after reset", gain, UNITY);
    gain_m = UNITY;

    // table walk: mute edges coincide with strobes
    foreach (VEC[i]) begin
      longint el, er, g_old;
      @(negedge clk);
      mute_n = VEC[i][48];
      valid = 1'b1; left = VEC[i][47:24]; right = VEC[i][23:0];
      g_old = gain_m;
      el = model_scale(sx(left), g_old);
      er = model_scale(sx(right), g_old);
      if (!VEC[i][48]) gain_m = (gain_m > STEP) ? gain_m - STEP : 0;
      else gain_m = UNITY;
      @(negedge clk);
      valid = 1'b0;
      check(out_valid == 1, "R6 out strobe", out_valid, 1);
      check(sx(out_left) == el, "R6 left scale", sx(out_left), el);
      check(sx(out_right) == er, "R2 right scale", sx(out_right), er);
      check(gain == gain_m, VEC[i][48] ? "R4 gain" : "R1 gain", gain, gain_m);
    end
    mute_n = 1'b1;
    idle(2);
    check(out_valid == 0, "R6 strobe single", out_valid, 0);

    // R2: equal inputs, equal outputs, mid-fade
    mute_n = 1'b0;
    strobe(24'h654321, 24'h654321);
    strobe(24'h9ABCDE, 24'h9ABCDE);
    check(out_left == out_right, "R2 equal", sx(out_right), sx(out_left));

    // R4: release without strobe
    @(negedge clk); mute_n = 1'b1;
    @(negedge clk);
    check(gain == UNITY, "R4 release no strobe", gain, UNITY);

    // R3: hold with no strobe
    mute_n = 1'b0;
    strobe(24'h0, 24'h0);
    idle(6);
    check(gain == UNITY - STEP, "R3 hold", gain, UNITY - STEP);

    // R3: full ramp
    for (int k = 1; k < 799; k++) strobe(24'h1, 24'h1);
    check(gain == 1087, "R3 after 799", gain, 1087);
    strobe(24'h7FFFFF, 24'h800000);
    check(gain == 0, "R3 after 800", gain, 0);
    strobe(24'h7FFFFF, 24'h800000);
    check(out_left == 0 && out_right == 0, "R7 silent out", sx(out_left), 0);
    strobe(24'h7FFFFF, 24'h800000);
    check(gain == 0, "R3 clamp", gain, 0);

    // R7: unity passes exactly
    @(negedge clk); mute_n = 1'b1;
    strobe(24'h800000, 24'h7FFFFF);
    check(out_left == 24'h800000, "R7 unity left", sx(out_left), sx(24'h800000));
    check(out_right == 24'h7FFFFF, "R7 unity right", sx(out_right), sx(24'h7FFFFF));

    // R5: bit clock loss
    check(lost == 0, "R5 active clock", lost, 0);
    bclk_run = 1'b0;
    idle(90);
    check(lost == 1, "R5 loss flagged", lost, 1);
    strobe(24'h100000, 24'h100000);
    check(gain == UNITY - STEP, "R5 loss fades", gain, UNITY - STEP);
    bclk_run = 1'b1;
    idle(12);
    check(lost == 0, "R5 loss cleared", lost, 0);
    check(gain == UNITY, "R5 unity after clear", gain, UNITY);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule